// File: doc/BRIEF.md
# Short-Gadget Chain Detector

This block watches the stream of retired instructions and splits it into sequences. Each sequence ends at an indirect control transfer: a return, an indirect jump or an indirect call. The terminating branch counts as part of the sequence. A sequence shorter than a programmable length limit is counted as "short". When a programmable number of short sequences arrive back to back, the block raises an alarm. Such runs are typical of chained code-reuse gadgets. A return whose target does not directly follow a call instruction raises the same alarm immediately.

The retirement stream is a valid-only stream. The monitor accepts every beat and never applies back-pressure, so it has no ready output, and a beat is consumed in the cycle its valid is high. The two thresholds are captured while the enable input is low and stay frozen while it is high. An alarm produces a one-cycle pulse and sets a sticky flag. The debug outputs show the current sequence length and the current run of short sequences.

Top module: `gadget_chain_monitor`

## Requirements
- R1: After reset, alarm_pulse, alarm_sticky, dbg_seq_len and dbg_chain_cnt are all zero.
- R2: dbg_seq_len counts retired non-branch instructions since the last indirect branch. It saturates at 2^LEN_W-1 and returns to zero in the cycle after an indirect branch retires.
- R3: A sequence's length is dbg_seq_len plus one for the branch, saturated at 2^LEN_W-1. A sequence is short when its length is below the captured length limit. A short sequence increments dbg_chain_cnt, saturating at 2^CNT_W-1. A long sequence sets dbg_chain_cnt to zero.
- R4: Suppose a short sequence brings the run count to at least the captured chain limit. Then alarm_pulse is high for exactly the next cycle, and dbg_chain_cnt is zero in that cycle.
- R5: A retiring indirect branch with is_return=1 and ret_call_preceded=0 causes alarm_pulse in the next cycle, whatever the run count. It also sets dbg_chain_cnt to zero.
- R6: alarm_sticky is set by every alarm and holds until sticky_clr is high in a cycle with no new alarm. A new alarm wins over a simultaneous clear.
- R7: While enable is low, both counters are held at zero, no alarm pulse is raised, and the thr_chain and thr_len pins are captured. While enable is high, changes on those pins have no effect.
- R8: A cycle with retire_vld low changes neither counter and raises no alarm, even if ind_branch is high.
- R9: The threshold pairs chain=8 with length limit 20 and chain=11 with length limit 6 both work. Eight sequences of length 19 raise the alarm under the first pair. Eleven sequences of length 5 raise it under the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitoring on; low clears counters and captures thresholds |
| thr_chain | input | CNT_W | Number of consecutive short sequences that alarms |
| thr_len | input | LEN_W | Length limit; sequences below it are short |
| retire_vld | input | 1 | One instruction retires this cycle |
| ind_branch | input | 1 | Retiring instruction is an indirect branch |
| is_return | input | 1 | That indirect branch is a return |
| ret_call_preceded | input | 1 | Return target directly follows a call |
| sticky_clr | input | 1 | Clears alarm_sticky |
| alarm_pulse | output | 1 | One-cycle alarm |
| alarm_sticky | output | 1 | Latched alarm |
| dbg_seq_len | output | LEN_W | Current sequence length (branch excluded) |
| dbg_chain_cnt | output | CNT_W | Current run of short sequences |

## Verification
The hardest situation to reach is a full run of short sequences of exactly the right length under each threshold pair. Random traffic rarely produces eight or eleven consecutive sequences that all stay below the limit, and the cases right at the limit are rarer still. Directed sequences therefore build runs of lengths 19, 20 and 5, drive the length counter into saturation, and change the threshold pins while the block is enabled. Seeded random traffic covers the rest and is compared each cycle against a bench model.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
  // Classified retirement beat, derived at the top from the raw stream.
  typedef struct packed {
    logic step;     // an instruction retires while monitoring
    logic seq_end;  // it is an indirect branch
    logic bad_ret;  // it is a return landing off a call site
  } gcm_evt_t;
endpackage

// File: rtl/gcm_thresh_latch.sv
module gcm_thresh_latch #(
  parameter int LEN_W = 6,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] thr_chain,
  input  logic [LEN_W-1:0] thr_len,
  output logic [CNT_W-1:0] lim_chain,
  output logic [LEN_W-1:0] lim_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_chain <= '0;
      lim_len   <= '0;
    end else if (!enable) begin
      lim_chain <= thr_chain;
      lim_len   <= thr_len;
    end
  end
endmodule

// File: rtl/gcm_len_counter.sv
module gcm_len_counter #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  gcm_pkg::gcm_evt_t evt,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] seq_len
);
  localparam logic [LEN_W-1:0] LMAX = {LEN_W{1'b1}};

  assign seq_len = (len_q == LMAX) ? LMAX : len_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 len_q <= '0;
    else if (!enable)           len_q <= '0;
    else if (evt.seq_end)       len_q <= '0;
    else if (evt.step && len_q != LMAX) len_q <= len_q + 1'b1;
  end
endmodule

// File: rtl/gcm_chain_tracker.sv
module gcm_chain_tracker #(
  parameter int LEN_W = 6,
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  gcm_pkg::gcm_evt_t evt,
  input  logic [LEN_W-1:0]  seq_len,
  input  logic [LEN_W-1:0]  lim_len,
  input  logic [CNT_W-1:0]  lim_chain,
  output logic [CNT_W-1:0]  chain_q,
  output logic              chain_hit
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             is_short;
  logic [CNT_W-1:0] chain_nx;

  assign is_short  = seq_len < lim_len;
  assign chain_nx  = !is_short ? '0 : (chain_q == CMAX) ? CMAX : chain_q + 1'b1;
  assign chain_hit = evt.seq_end && is_short && (chain_nx >= lim_chain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chain_q <= '0;
    else if (!enable)     chain_q <= '0;
    else if (evt.seq_end) chain_q <= (chain_hit || evt.bad_ret) ? '0 : chain_nx;
  end
endmodule

// File: rtl/gcm_alarm_unit.sv
module gcm_alarm_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic sticky_clr,
  output logic alarm_pulse,
  output logic alarm_sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_pulse  <= 1'b0;
      alarm_sticky <= 1'b0;
    end else begin
      alarm_pulse  <= fire;
      alarm_sticky <= fire | (alarm_sticky & ~sticky_clr);
    end
  end
endmodule

// File: rtl/gadget_chain_monitor.sv
module gadget_chain_monitor #(
  parameter int LEN_W = 6,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] thr_chain,
  input  logic [LEN_W-1:0] thr_len,
  input  logic             retire_vld,
  input  logic             ind_branch,
  input  logic             is_return,
  input  logic             ret_call_preceded,
  input  logic             sticky_clr,
  output logic             alarm_pulse,
  output logic             alarm_sticky,
  output logic [LEN_W-1:0] dbg_seq_len,
  output logic [CNT_W-1:0] dbg_chain_cnt
);
  gcm_pkg::gcm_evt_t evt;
  logic [CNT_W-1:0]  lim_chain;
  logic [LEN_W-1:0]  lim_len;
  logic [LEN_W-1:0]  seq_len;
  logic              chain_hit;

  assign evt.step    = enable & retire_vld;
  assign evt.seq_end = evt.step & ind_branch;
  assign evt.bad_ret = evt.seq_end & is_return & ~ret_call_preceded;

  gcm_thresh_latch #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .thr_chain(thr_chain), .thr_len(thr_len),
    .lim_chain(lim_chain), .lim_len(lim_len)
  );

  gcm_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .enable(enable), .evt(evt),
    .len_q(dbg_seq_len), .seq_len(seq_len)
  );

  gcm_chain_tracker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .enable(enable), .evt(evt),
    .seq_len(seq_len), .lim_len(lim_len), .lim_chain(lim_chain),
    .chain_q(dbg_chain_cnt), .chain_hit(chain_hit)
  );

  gcm_alarm_unit u_alarm (
    .clk(clk), .rst_n(rst_n), .fire(chain_hit | evt.bad_ret),
    .sticky_clr(sticky_clr),
    .alarm_pulse(alarm_pulse), .alarm_sticky(alarm_sticky)
  );
endmodule

// File: rtl/gcm_checker.sv
module gcm_checker #(
  parameter int LEN_W = 6,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             retire_vld,
  input logic             ind_branch,
  input logic             is_return,
  input logic             ret_call_preceded,
  input logic             sticky_clr,
  input logic             alarm_pulse,
  input logic             alarm_sticky,
  input logic [LEN_W-1:0] dbg_seq_len,
  input logic [CNT_W-1:0] dbg_chain_cnt
);
  p_branch_clears_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && retire_vld && ind_branch) |=> dbg_seq_len == '0);

  p_pulse_clears_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> dbg_chain_cnt == '0);

  p_bad_return_alarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && retire_vld && ind_branch && is_return && !ret_call_preceded) |=> alarm_pulse);

  p_pulse_sets_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> alarm_sticky);

  p_sticky_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_sticky && !sticky_clr) |=> alarm_sticky);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (dbg_seq_len == '0 && dbg_chain_cnt == '0 && !alarm_pulse));

  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !retire_vld) |=> ($stable(dbg_seq_len) && $stable(dbg_chain_cnt) && !alarm_pulse));
endmodule

bind gadget_chain_monitor gcm_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_gcm_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .retire_vld(retire_vld),
  .ind_branch(ind_branch), .is_return(is_return),
  .ret_call_preceded(ret_call_preceded), .sticky_clr(sticky_clr),
  .alarm_pulse(alarm_pulse), .alarm_sticky(alarm_sticky),
  .dbg_seq_len(dbg_seq_len), .dbg_chain_cnt(dbg_chain_cnt)
);

// File: tb/test_gadget_chain_monitor.sv
module test_gadget_chain_monitor;
  localparam int LEN_W = 6;
  localparam int CNT_W = 5;
  localparam int LMAX  = (1 << LEN_W) - 1;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] thr_chain = '0;
  logic [LEN_W-1:0] thr_len = '0;
  logic             retire_vld = 1'b0, ind_branch = 1'b0, is_return = 1'b0;
  logic             ret_call_preceded = 1'b1, sticky_clr = 1'b0;
  logic             alarm_pulse, alarm_sticky;
  logic [LEN_W-1:0] dbg_seq_len;
  logic [CNT_W-1:0] dbg_chain_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_len = 0, m_chain = 0, m_capn = 0, m_caps = 0;
  bit m_pulse = 0, m_sticky = 0;

  always #5 clk = ~clk;

  gadget_chain_monitor #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_gadget_chain_monitor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .thr_chain(thr_chain), .thr_len(thr_len),
    .retire_vld(retire_vld), .ind_branch(ind_branch), .is_return(is_return),
    .ret_call_preceded(ret_call_preceded), .sticky_clr(sticky_clr),
    .alarm_pulse(alarm_pulse), .alarm_sticky(alarm_sticky),
    .dbg_seq_len(dbg_seq_len), .dbg_chain_cnt(dbg_chain_cnt)
  );

  function automatic int sat_inc(int v, int mx);
    return (v >= mx) ? mx : v + 1;
  endfunction

  function automatic bit is_short_seq(int len_before, int lim);
    return sat_inc(len_before, LMAX) < lim;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference update for one clock edge, using the inputs held at that edge.
  task automatic model_step();
    bit fire = 0;
    if (!enable) begin
      m_len = 0; m_chain = 0;
    end else if (retire_vld) begin
      if (ind_branch) begin
        bit sh = is_short_seq(m_len, m_caps);
        int cn = sh ? sat_inc(m_chain, CMAX) : 0;
        bit hit = sh && (cn >= m_capn);
        bit bad = is_return && !ret_call_preceded;
        fire = hit || bad;
        m_chain = fire ? 0 : cn;
        m_len = 0;
      end else begin
        m_len = sat_inc(m_len, LMAX);
      end
    end
    m_pulse = fire;
    m_sticky = fire | (m_sticky & !sticky_clr);
    if (!enable) begin m_capn = int'(thr_chain); m_caps = int'(thr_len); end
  endtask

  task automatic cyc(bit en, bit rv, bit ib, bit ir, bit cp, bit clr);
    @(negedge clk);
    enable = en; retire_vld = rv; ind_branch = ib; is_return = ir;
    ret_call_preceded = cp; sticky_clr = clr;
    @(posedge clk);
    model_step();
    #1;
    chk("R2 seq_len", int'(dbg_seq_len), m_len);
    chk("R3 chain_cnt", int'(dbg_chain_cnt), m_chain);
    chk("R4 alarm_pulse", int'(alarm_pulse), int'(m_pulse));
    chk("R6 alarm_sticky", int'(alarm_sticky), int'(m_sticky));
  endtask

  task automatic seq(int plain, bit ret, bit cp);
    for (int i = 0; i < plain; i++) cyc(1, 1, 0, 0, 1, 0);
    cyc(1, 1, 1, ret, cp, 0);
  endtask

  task automatic config_thr(int n, int s);
    thr_chain = CNT_W'(n); thr_len = LEN_W'(s);
    cyc(0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #22 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 pulse", int'(alarm_pulse), 0);
    chk("R1 sticky", int'(alarm_sticky), 0);
    chk("R1 seq_len", int'(dbg_seq_len), 0);
    chk("R1 chain", int'(dbg_chain_cnt), 0);

    // R9: chain 8, length limit 20
    config_thr(8, 20);
    for (int k = 0; k < 7; k++) seq(18, 0, 1);
    chk("R3 seven short", int'(dbg_chain_cnt), 7);
    seq(18, 0, 1);
    chk("R9 pair 8/20 alarm", int'(alarm_pulse), 1);
    chk("R4 chain cleared", int'(dbg_chain_cnt), 0);
    seq(18, 0, 1);
    seq(19, 0, 1);
    chk("R3 long clears chain", int'(dbg_chain_cnt), 0);
    cyc(1, 0, 0, 0, 1, 1);
    chk("R6 sticky cleared", int'(alarm_sticky), 0);

    // R9: chain 11, length limit 6
    config_thr(11, 6);
    for (int k = 0; k < 10; k++) seq(4, 1, 1);
    chk("R9 no early alarm", int'(alarm_sticky), 0);
    seq(4, 1, 1);
    chk("R9 pair 11/6 alarm", int'(alarm_pulse), 1);

    // R5: bad return with empty chain; good long return silent
    seq(10, 1, 1);
    chk("R5 good return quiet", int'(alarm_pulse), 0);
    seq(10, 1, 0);
    chk("R5 bad return alarm", int'(alarm_pulse), 1);

    // R6: new alarm wins over clear
    cyc(1, 1, 1, 1, 0, 1);
    chk("R6 set beats clear", int'(alarm_sticky), 1);

    // R8: branch flag without valid is ignored
    cyc(1, 1, 0, 0, 1, 0);
    cyc(1, 1, 0, 0, 1, 0);
    cyc(1, 0, 1, 1, 0, 0);
    chk("R8 len kept", int'(dbg_seq_len), 2);
    chk("R8 no alarm", int'(alarm_pulse), 0);

    // R7: threshold pins ignored while enabled
    thr_chain = CNT_W'(1); thr_len = LEN_W'(40);
    seq(3, 0, 1);
    chk("R7 thr change ignored", int'(alarm_pulse), 0);
    cyc(0, 1, 1, 1, 0, 0);
    chk("R7 disabled no pulse", int'(alarm_pulse), 0);
    chk("R7 disabled len zero", int'(dbg_seq_len), 0);

    // R2: saturation
    config_thr(11, 6);
    for (int i = 0; i < 70; i++) cyc(1, 1, 0, 0, 1, 0);
    chk("R2 saturated", int'(dbg_seq_len), LMAX);
    cyc(1, 1, 1, 0, 1, 0);
    chk("R2 cleared after branch", int'(dbg_seq_len), 0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit en = ($urandom_range(0, 99) >= 2);
      if (!en) begin
        thr_chain = CNT_W'($urandom_range(1, 12));
        thr_len   = LEN_W'($urandom_range(1, 25));
      end
      cyc(en, $urandom_range(0, 9) < 8, $urandom_range(0, 3) == 0,
          $urandom_range(0, 1) == 1, $urandom_range(0, 19) != 0,
          $urandom_range(0, 29) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule